// File: doc/BRIEF.md
# Masked Calendar Alarm Comparator

This block holds four alarm registers (seconds, minutes, hours and day of month) and compares them against the current BCD time, which an external clock supplies. The external clock asserts a one-cycle tick whenever a new second becomes valid. Each alarm register carries an ignore bit in its top position. A field whose ignore bit is clear must equal the current time. A field whose ignore bit is set always counts as matching. Ignoring selected fields gives an alarm that repeats once a minute, hour, day or month.

When every field matches on a tick, a read-only alarm flag sets. The host clears it by strobing a read of the flags register. If an interrupt enable bit is on, the flag also drives a shared interrupt pin. That pin can be active high or active low. It can either pulse for a fixed number of clock cycles or hold its level until the flag clears.

The interrupt side is a three-state controller. IRQ_IDLE is quiet. IRQ_HOLD is the level-mode active state. IRQ_PULSE is the timed pulse. The transitions are:
- IRQ_IDLE to IRQ_PULSE on a set event while enabled in pulse mode.
- IRQ_IDLE to IRQ_HOLD on a set event while enabled in level mode, or when the flag is already set, level mode is selected and the enable turns on.
- IRQ_HOLD to IRQ_IDLE when the flag is cleared or the enable drops.
- IRQ_PULSE restarts its count on a new set event.
- IRQ_PULSE to IRQ_IDLE when the count expires.

Top module: `cal_alarm_cmp`

## Requirements
- R1: After reset all four alarm registers, the control register and the alarm flag read 0x00. With active-low polarity selected by reset, irq_out is 1.
- R2: The register selects are:
  - 0: seconds alarm
  - 1: minutes alarm
  - 2: hours alarm
  - 3: date alarm
  - 4: control register. Bit 0 is the interrupt enable, bit 1 is polarity (1 = active high), bit 2 is pulse mode (1 = pulse). Its other bits read 0.
  - 5: flags register. Bit 0 is the alarm flag. Writes to this select have no effect.

  rd_data shows the selected register combinationally.
- R3: On a cycle with tick high, if every alarm field whose bit 7 is 0 has bits 6:0 equal to the current value's bits 6:0, the alarm flag reads 1 from the following cycle. A mismatch in any participating field leaves the flag at 0.
- R4: A field whose bit 7 is 1 is excluded from the comparison. With all four bit 7s set, every tick sets the flag.
- R5: Without tick, a matching time never sets the flag.
- R6: A flag_rd pulse clears the flag in the following cycle. If flag_rd coincides with a tick that matches, the flag stays 1.
- R7: With the enable at 0, irq_out stays inactive even though the flag sets.
- R8: In level mode with the enable set, irq_out is active from the cycle after the matching tick until the cycle after the flag is cleared.
- R9: In pulse mode with the enable set, irq_out is active for exactly PULSE_CYCLES cycles starting the cycle after the matching tick. The flag stays set after the pulse ends.
- R10: When polarity is 1, the active level of irq_out is 1. When polarity is 0, the active level is 0 and the idle level is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | One-cycle marker: the current time is a new second |
| cur_sec | input | 8 | Current seconds, BCD |
| cur_min | input | 8 | Current minutes, BCD |
| cur_hour | input | 8 | Current hours, BCD |
| cur_date | input | 8 | Current day of month, BCD |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 3 | Register select for writes |
| wr_data | input | 8 | Write data |
| rd_sel | input | 3 | Register select for reads |
| rd_data | output | 8 | Read data of the selected register |
| flag_rd | input | 1 | Flags-register read strobe, clears the alarm flag |
| irq_out | output | 1 | Alarm interrupt pin |

## Verification
The assertions assume that tick lasts a single cycle and that the current-time inputs are stable whenever tick is high. They also assume that the control register does not change while a pulse is running. The bench drives all inputs on the falling edge. It raises tick for exactly one cycle with the time already settled. It rewrites the control register only while the interrupt controller is idle and the flag has been cleared.

// File: rtl/alm_pkg.sv
package alm_pkg;
    localparam int NUM_FIELDS = 4;
    localparam int SEL_W      = 3;

    localparam logic [SEL_W-1:0] SEL_SEC   = 3'd0;
    localparam logic [SEL_W-1:0] SEL_MIN   = 3'd1;
    localparam logic [SEL_W-1:0] SEL_HOUR  = 3'd2;
    localparam logic [SEL_W-1:0] SEL_DATE  = 3'd3;
    localparam logic [SEL_W-1:0] SEL_CTRL  = 3'd4;
    localparam logic [SEL_W-1:0] SEL_FLAGS = 3'd5;

    typedef enum logic [1:0] {
        IRQ_IDLE  = 2'd0,
        IRQ_HOLD  = 2'd1,
        IRQ_PULSE = 2'd2
    } irq_state_e;

    typedef struct packed {
        logic pulse_mode;
        logic pol_high;
        logic irq_en;
    } alm_ctrl_t;
endpackage

// File: rtl/alm_regs.sv
module alm_regs
    import alm_pkg::*;
(
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr_en,
    input  logic [SEL_W-1:0]              wr_sel,
    input  logic [7:0]                    wr_data,
    output logic [NUM_FIELDS-1:0][7:0]    alarm_q,
    output alm_ctrl_t                     ctrl_q
);
    localparam int IDX_W = $clog2(NUM_FIELDS);

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            alarm_q <= '0;
            ctrl_q  <= '0;
        end else if (wr_en) begin
            if (wr_sel < SEL_W'(NUM_FIELDS)) begin
                alarm_q[wr_sel[IDX_W-1:0]] <= wr_data;
            end else if (wr_sel == SEL_CTRL) begin
                ctrl_q <= alm_ctrl_t'(wr_data[2:0]);
            end
        end
    end
endmodule

// File: rtl/alm_field_cmp.sv
module alm_field_cmp
    import alm_pkg::*;
(
    input  logic [NUM_FIELDS-1:0][7:0] alarm,
    input  logic [NUM_FIELDS-1:0][7:0] cur,
    output logic [NUM_FIELDS-1:0]      ignored,
    output logic                       hit
);
    logic [NUM_FIELDS-1:0] field_ok;

    genvar g;
    generate
        for (g = 0; g < NUM_FIELDS; g++) begin : g_field
            assign ignored[g]  = alarm[g][7];
            assign field_ok[g] = alarm[g][7] | (alarm[g][6:0] == cur[g][6:0]);
        end
    endgenerate

    assign hit = &field_ok;
endmodule

// File: rtl/alm_irq_ctrl.sv
module alm_irq_ctrl
    import alm_pkg::*;
#(
    parameter int PULSE_CYCLES = 4
) (
    input  logic      clk,
    input  logic      rst_n,
    input  logic      tick,
    input  logic      hit,
    input  logic      flag_rd,
    input  alm_ctrl_t ctrl,
    output logic      flag_q,
    output logic      irq_out
);
    localparam int CW = (PULSE_CYCLES > 1) ? $clog2(PULSE_CYCLES) : 1;
    localparam logic [CW-1:0] CNT_LOAD = CW'(PULSE_CYCLES - 1);

    irq_state_e state_q, state_d;
    logic [CW-1:0] cnt_q;
    logic set_evt;
    logic active;

    assign set_evt = tick & hit;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            flag_q <= 1'b0;
        end else if (set_evt) begin
            flag_q <= 1'b1;
        end else if (flag_rd) begin
            flag_q <= 1'b0;
        end
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            IRQ_IDLE: begin
                if (ctrl.irq_en && set_evt) begin
                    state_d = ctrl.pulse_mode ? IRQ_PULSE : IRQ_HOLD;
                end else if (ctrl.irq_en && !ctrl.pulse_mode && flag_q && !flag_rd) begin
                    state_d = IRQ_HOLD;
                end
            end
            IRQ_HOLD: begin
                if (!ctrl.irq_en || (flag_rd && !set_evt)) begin
                    state_d = IRQ_IDLE;
                end
            end
            IRQ_PULSE: begin
                if (ctrl.irq_en && set_evt) begin
                    state_d = IRQ_PULSE;
                end else if (cnt_q == '0) begin
                    state_d = IRQ_IDLE;
                end
            end
            default: state_d = IRQ_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= IRQ_IDLE;
            cnt_q   <= '0;
        end else begin
            state_q <= state_d;
            if (state_d == IRQ_PULSE && (state_q != IRQ_PULSE || set_evt)) begin
                cnt_q <= CNT_LOAD;
            end else if (state_q == IRQ_PULSE && cnt_q != '0) begin
                cnt_q <= cnt_q - 1'b1;
            end
        end
    end

    always_comb begin
        active  = (state_q != IRQ_IDLE);
        irq_out = ctrl.pol_high ? active : ~active;
    end

    AST_FLAG_SETS_ON_HIT: assert property (@(posedge clk) disable iff (!rst_n)
        set_evt |=> flag_q); // R3
    AST_FLAG_CLEARS_ON_READ: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_rd && !set_evt) |=> !flag_q); // R6
    AST_FLAG_NEEDS_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        (flag_q && !$past(flag_q)) |-> $past(set_evt)); // R5
    AST_HOLD_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == IRQ_HOLD) |-> flag_q); // R8
    AST_PULSE_CNT_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == IRQ_PULSE) |-> (cnt_q <= CNT_LOAD)); // R9
    AST_DISABLED_STAYS_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (!ctrl.irq_en && state_q == IRQ_IDLE) |=> (state_q == IRQ_IDLE)); // R7
endmodule

// File: rtl/cal_alarm_cmp.sv
module cal_alarm_cmp
    import alm_pkg::*;
#(
    parameter int PULSE_CYCLES = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             tick,
    input  logic [7:0]       cur_sec,
    input  logic [7:0]       cur_min,
    input  logic [7:0]       cur_hour,
    input  logic [7:0]       cur_date,
    input  logic             wr_en,
    input  logic [SEL_W-1:0] wr_sel,
    input  logic [7:0]       wr_data,
    input  logic [SEL_W-1:0] rd_sel,
    output logic [7:0]       rd_data,
    input  logic             flag_rd,
    output logic             irq_out
);
    logic [NUM_FIELDS-1:0][7:0] alarm_q;
    logic [NUM_FIELDS-1:0][7:0] cur_vec;
    logic [NUM_FIELDS-1:0]      ignored;
    alm_ctrl_t                  ctrl_q;
    logic                       hit;
    logic                       flag_q;

    assign cur_vec = {cur_date, cur_hour, cur_min, cur_sec};

    alm_regs u_regs (
        .clk     (clk),
        .rst_n   (rst_n),
        .wr_en   (wr_en),
        .wr_sel  (wr_sel),
        .wr_data (wr_data),
        .alarm_q (alarm_q),
        .ctrl_q  (ctrl_q)
    );

    alm_field_cmp u_cmp (
        .alarm   (alarm_q),
        .cur     (cur_vec),
        .ignored (ignored),
        .hit     (hit)
    );

    alm_irq_ctrl #(.PULSE_CYCLES(PULSE_CYCLES)) u_irq (
        .clk     (clk),
        .rst_n   (rst_n),
        .tick    (tick),
        .hit     (hit),
        .flag_rd (flag_rd),
        .ctrl    (ctrl_q),
        .flag_q  (flag_q),
        .irq_out (irq_out)
    );

    always_comb begin
        rd_data = 8'h00;
        unique case (rd_sel)
            SEL_SEC:   rd_data = alarm_q[0];
            SEL_MIN:   rd_data = alarm_q[1];
            SEL_HOUR:  rd_data = alarm_q[2];
            SEL_DATE:  rd_data = alarm_q[3];
            SEL_CTRL:  rd_data = {5'b0, ctrl_q};
            SEL_FLAGS: rd_data = {7'b0, flag_q};
            default:   rd_data = 8'h00;
        endcase
    end

    AST_ALL_IGNORED_HITS: assert property (@(posedge clk) disable iff (!rst_n)
        (&ignored) |-> hit); // R4
endmodule

// File: tb/cal_alarm_cmp_bench.sv
module cal_alarm_cmp_bench;
    localparam int PW = 4;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       tick = 1'b0;
    logic [7:0] cur_sec = 8'h00, cur_min = 8'h00, cur_hour = 8'h00, cur_date = 8'h01;
    logic       wr_en = 1'b0;
    logic [2:0] wr_sel = 3'd0;
    logic [7:0] wr_data = 8'h00;
    logic [2:0] rd_sel = 3'd0;
    logic [7:0] rd_data;
    logic       flag_rd = 1'b0;
    logic       irq_out;

    int n_checks = 0;
    int n_fail = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    cal_alarm_cmp #(.PULSE_CYCLES(PW)) u_cal_alarm_cmp (
        .clk(clk), .rst_n(rst_n), .tick(tick),
        .cur_sec(cur_sec), .cur_min(cur_min), .cur_hour(cur_hour), .cur_date(cur_date),
        .wr_en(wr_en), .wr_sel(wr_sel), .wr_data(wr_data),
        .rd_sel(rd_sel), .rd_data(rd_data), .flag_rd(flag_rd), .irq_out(irq_out)
    );

    task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h at %0t", req, act, exp, $time);
        end
    endtask

    task automatic wr(input logic [2:0] sel, input logic [7:0] d);
        wr_en = 1'b1; wr_sel = sel; wr_data = d;
        @(posedge clk); @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [2:0] sel, output logic [7:0] d);
        rd_sel = sel; #1; d = rd_data;
    endtask

    task automatic set_time(input logic [7:0] dt, input logic [7:0] h, input logic [7:0] m, input logic [7:0] s);
        cur_date = dt; cur_hour = h; cur_min = m; cur_sec = s;
    endtask

    task automatic do_tick();
        tick = 1'b1;
        @(posedge clk); @(negedge clk);
        tick = 1'b0;
    endtask

    task automatic clear_flag();
        flag_rd = 1'b1;
        @(posedge clk); @(negedge clk);
        flag_rd = 1'b0;
    endtask

    function automatic logic [7:0] flag_now();
        return {7'b0, u_flag_view};
    endfunction

    logic u_flag_view;
    always_comb u_flag_view = rd_data[0];

    task automatic get_flag(output logic [7:0] f);
        rd(3'd5, f);
    endtask

    task automatic set_alarm(input logic [7:0] dt, input logic [7:0] h, input logic [7:0] m, input logic [7:0] s);
        wr(3'd0, s); wr(3'd1, m); wr(3'd2, h); wr(3'd3, dt);
    endtask

    task automatic test_reset();
        logic [7:0] v;
        for (int i = 0; i < 6; i++) begin
            rd(3'(i), v);
            chk("R1 reg after reset", v, 8'h00);
        end
        chk("R1 irq idle after reset", {7'b0, irq_out}, 8'h01);
    endtask

    task automatic test_regs();
        logic [7:0] v;
        wr(3'd0, 8'hB1); wr(3'd1, 8'h42); wr(3'd2, 8'h93); wr(3'd3, 8'h17);
        rd(3'd0, v); chk("R2 sec alarm", v, 8'hB1);
        rd(3'd1, v); chk("R2 min alarm", v, 8'h42);
        rd(3'd2, v); chk("R2 hour alarm", v, 8'h93);
        rd(3'd3, v); chk("R2 date alarm", v, 8'h17);
        wr(3'd4, 8'hFF);
        rd(3'd4, v); chk("R2 ctrl bits", v, 8'h07);
        wr(3'd4, 8'h00);
        wr(3'd5, 8'hFF);
        rd(3'd5, v); chk("R2 flags write ignored", v, 8'h00);
    endtask

    task automatic test_match();
        logic [7:0] v;
        set_alarm(8'h25, 8'h12, 8'h15, 8'h30);
        set_time(8'h25, 8'h12, 8'h15, 8'h29);
        do_tick(); get_flag(v); chk("R3 sec mismatch", v, 8'h00);
        set_time(8'h24, 8'h12, 8'h15, 8'h30);
        do_tick(); get_flag(v); chk("R3 date mismatch", v, 8'h00);
        set_time(8'h25, 8'h12, 8'h15, 8'h30);
        do_tick(); get_flag(v); chk("R3 full match", v, 8'h01);
        clear_flag();
    endtask

    task automatic test_ignore();
        logic [7:0] v;
        set_alarm(8'h25, 8'h12, 8'h15, 8'hB0);
        set_time(8'h25, 8'h12, 8'h15, 8'h47);
        do_tick(); get_flag(v); chk("R4 seconds ignored", v, 8'h01);
        clear_flag();
        set_time(8'h25, 8'h13, 8'h15, 8'h47);
        do_tick(); get_flag(v); chk("R4 hour still compared", v, 8'h00);
        set_alarm(8'h80, 8'h80, 8'h80, 8'h80);
        set_time(8'h03, 8'h07, 8'h59, 8'h01);
        do_tick(); get_flag(v); chk("R4 all ignored fires", v, 8'h01);
        clear_flag();
        set_time(8'h31, 8'h23, 8'h00, 8'h02);
        do_tick(); get_flag(v); chk("R4 all ignored fires again", v, 8'h01);
        clear_flag();
    endtask

    task automatic test_no_tick();
        logic [7:0] v;
        set_alarm(8'h25, 8'h12, 8'h15, 8'h30);
        set_time(8'h25, 8'h12, 8'h15, 8'h30);
        repeat (5) @(negedge clk);
        get_flag(v); chk("R5 no tick no flag", v, 8'h00);
    endtask

    task automatic test_clear();
        logic [7:0] v;
        do_tick(); get_flag(v); chk("R6 setup flag", v, 8'h01);
        clear_flag(); get_flag(v); chk("R6 read clears", v, 8'h00);
        do_tick();
        flag_rd = 1'b1; tick = 1'b1;
        @(posedge clk); @(negedge clk);
        flag_rd = 1'b0; tick = 1'b0;
        get_flag(v); chk("R6 match wins over clear", v, 8'h01);
        clear_flag();
    endtask

    task automatic test_disabled();
        logic [7:0] v;
        wr(3'd4, 8'h00);
        do_tick(); get_flag(v); chk("R7 flag sets", v, 8'h01);
        chk("R7 irq inactive", {7'b0, irq_out}, 8'h01);
        repeat (3) @(negedge clk);
        chk("R7 irq still inactive", {7'b0, irq_out}, 8'h01);
        clear_flag();
    endtask

    task automatic test_level();
        wr(3'd4, 8'h03);
        chk("R8 idle low before", {7'b0, irq_out}, 8'h00);
        do_tick();
        chk("R8 active after tick", {7'b0, irq_out}, 8'h01);
        repeat (10) @(negedge clk);
        chk("R8 active held", {7'b0, irq_out}, 8'h01);
        clear_flag();
        chk("R8 inactive after clear", {7'b0, irq_out}, 8'h00);
    endtask

    task automatic test_pulse();
        logic [7:0] v;
        wr(3'd4, 8'h07);
        do_tick();
        for (int i = 0; i < PW; i++) begin
            chk("R9 pulse active", {7'b0, irq_out}, 8'h01);
            @(negedge clk);
        end
        chk("R9 pulse ended", {7'b0, irq_out}, 8'h00);
        get_flag(v); chk("R9 flag remains", v, 8'h01);
        clear_flag();
    endtask

    task automatic test_polarity();
        wr(3'd4, 8'h01);
        chk("R10 low polarity idle high", {7'b0, irq_out}, 8'h01);
        do_tick();
        chk("R10 low polarity active low", {7'b0, irq_out}, 8'h00);
        clear_flag();
        chk("R10 low polarity back high", {7'b0, irq_out}, 8'h01);
        wr(3'd4, 8'h00);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        test_reset();
        test_regs();
        test_match();
        test_ignore();
        test_no_tick();
        test_clear();
        test_disabled();
        test_level();
        test_pulse();
        test_polarity();
        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected done");
            $display("== %0d vectors applied, %0d miscompares ==", n_checks, n_fail);
            $finish;
        end
    end
endmodule